// File: doc/BRIEF.md
# Floating-Point Issue Interlock

This block sits at the boundary between instruction decode and execute in a pipeline with four execution units of different latency. There is a one-cycle integer unit, a seven-stage pipelined multiplier, a four-stage pipelined adder and a 24-cycle divider that is not pipelined. Each cycle the decoder presents an instruction: its unit, up to two source registers and an optional destination register. In the same cycle the block answers with a combinational `stall`. When the request is present and `stall` is low, the instruction issues at the clock edge and the block updates its in-flight tracking.

Three structures keep that tracking. A per-register pending table counts down the cycles until each result is ready. A slot shift register holds one bit per future cycle in which a result will use the single write-back port. A two-state sequencer for the divider has the states DV_IDLE and DV_BUSY. Its transitions are *launch* (DV_IDLE to DV_BUSY on a divide issue) and *retire* (DV_BUSY to DV_IDLE when its countdown reaches zero). Because each unit has its own latency, results may complete out of order. The interlock therefore also blocks a write-after-write onto a register that still has a result pending.

Top module: `fpi_issue_guard`

## Requirements
- R1: While reset is held and in the first cycle after it, `stall`, `div_busy` and every bit of `wb_slots` are low.
- R2: The unit encodings are 0 integer (latency 1), 1 multiply (latency 7), 2 add (latency 4) and 3 divide (latency 24). An instruction issued in cycle t with latency L and a valid destination makes that register unready in cycles t+1 through t+L.
- R3: A request whose valid source (A or B) names an unready register stalls in that same cycle.
- R4: A request whose valid destination names an unready register stalls (write-after-write).
- R5: A divide issued in cycle t holds `div_busy` high in cycles t+1 through t+24. A divide request in any of those cycles stalls.
- R6: Bit k of `wb_slots` is high when an issued instruction with a valid destination writes back k cycles from now. An instruction issued in cycle t with latency L writes back in cycle t+L.
- R7: A request with a valid destination and latency L stalls when bit L of `wb_slots` is already high. An instruction without a valid destination reserves no slot and is never stalled for a slot.
- R8: With no request, `stall` is low and the tracking state changes only by the passing of time. A stalled request leaves the tracking unchanged.
- R9: A source whose valid flag is low never causes a stall, whatever register it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_req | input | 1 | An instruction is waiting to leave decode |
| unit_sel | input | 2 | Target unit: 0 int, 1 mul, 2 add, 3 div |
| src_a | input | REG_AW | First source register |
| src_a_vld | input | 1 | First source is read |
| src_b | input | REG_AW | Second source register |
| src_b_vld | input | 1 | Second source is read |
| dst | input | REG_AW | Destination register |
| dst_vld | input | 1 | Instruction writes `dst` |
| stall | output | 1 | Hold the instruction in decode this cycle |
| div_busy | output | 1 | Divider occupied |
| wb_slots | output | LAT_MAX+1 | Reserved write-back cycles, bit k = k cycles ahead |

## Verification
The first pattern is a directed sweep over every producer and consumer unit pair with a true dependence. It measures the stall length, which should equal the producer's latency, so it tells the four latencies apart. A second directed sequence offsets a multiply and an add so that both land on the same write-back cycle. It then repeats the sequence without a destination, which separates a slot conflict from a dependence stall. Back-to-back divides on unrelated registers isolate the divider's occupancy. A long pseudo-random stream over four registers, with idle cycles mixed in, is checked every cycle against an absolute-cycle model. That model covers the stall output, the divider flag and each slot bit, so the stream exercises overlapping hazards, invalid sources and stalls with the request held.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

    typedef enum logic [1:0] {
        U_INT = 2'd0,
        U_MUL = 2'd1,
        U_ADD = 2'd2,
        U_DIV = 2'd3
    } unit_t;

    typedef enum logic {
        DV_IDLE = 1'b0,
        DV_BUSY = 1'b1
    } div_state_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/fpi_pend_table.sv
module fpi_pend_table #(
    parameter int REG_AW = 5,
    parameter int CNT_W  = 5,
    parameter int LAT_MAX = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_AW-1:0]     wr_idx,
    input  logic [CNT_W-1:0]      wr_lat,
    output logic [(1<<REG_AW)-1:0] pend
);
    localparam int NREG = 1 << REG_AW;

    logic [CNT_W-1:0] cnt [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[i] <= '0;
            else if (wr_en && wr_idx == REG_AW'(i))
                cnt[i] <= wr_lat;
            else if (cnt[i] != '0)
                cnt[i] <= cnt[i] - 1'b1;
        end
        assign pend[i] = (cnt[i] != '0);

        // R2: a count never exceeds the longest latency
        assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[i] <= CNT_W'(LAT_MAX));
    end

    // R2: a written register is pending in the following cycle
    assert_write_pends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lat != '0) |=> pend[$past(wr_idx)]);

endmodule

// File: rtl/fpi_wb_ring.sv
module fpi_wb_ring #(
    parameter int SLOT_N = 25,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsv,
    input  logic [CNT_W-1:0]  lat,
    output logic              clash,
    output logic [SLOT_N-1:0] slots
);
    logic [SLOT_N-1:0] slots_n;

    always_comb begin
        slots_n = slots >> 1;
        if (rsv)
            slots_n = slots_n | (SLOT_N'(1) << (lat - 1'b1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            slots <= '0;
        else
            slots <= slots_n;
    end

    assign clash = slots[lat];

    // R7: the top never reserves a slot that is already claimed
    assert_no_double_rsv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsv |-> !slots[lat]);

    // R6: a reservation appears one position lower in the next cycle
    assert_rsv_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsv |=> slots[$past(lat) - 1'b1]);

endmodule

// File: rtl/fpi_div_seq.sv
module fpi_div_seq
    import fpi_pkg::*;
#(
    parameter int LAT_DIV = 24,
    parameter int CNT_W   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy
);
    div_state_t       state, state_n;
    logic [CNT_W-1:0] left, left_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DV_IDLE;
            left  <= '0;
        end else begin
            state <= state_n;
            left  <= left_n;
        end
    end

    always_comb begin
        state_n = state;
        left_n  = left;
        unique case (state)
            DV_IDLE: begin
                if (launch) begin
                    state_n = DV_BUSY;
                    left_n  = CNT_W'(LAT_DIV - 1);
                end
            end
            DV_BUSY: begin
                if (left == '0)
                    state_n = DV_IDLE;
                else
                    left_n = left - 1'b1;
            end
            default: state_n = DV_IDLE;
        endcase
    end

    assign busy = (state == DV_BUSY);

    // R5: a launch is only accepted from idle
    assert_launch_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> state == DV_IDLE);

    // R5: a launch makes the divider busy in the next cycle
    assert_launch_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

endmodule

// File: rtl/fpi_issue_guard.sv
module fpi_issue_guard
    import fpi_pkg::*;
#(
    parameter int REG_AW  = 5,
    parameter int LAT_INT = 1,
    parameter int LAT_MUL = 7,
    parameter int LAT_ADD = 4,
    parameter int LAT_DIV = 24,
    localparam int LAT_MAX = max_of4(LAT_INT, LAT_MUL, LAT_ADD, LAT_DIV),
    localparam int SLOT_N  = LAT_MAX + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_req,
    input  logic [1:0]        unit_sel,
    input  logic [REG_AW-1:0] src_a,
    input  logic              src_a_vld,
    input  logic [REG_AW-1:0] src_b,
    input  logic              src_b_vld,
    input  logic [REG_AW-1:0] dst,
    input  logic              dst_vld,
    output logic              stall,
    output logic              div_busy,
    output logic [SLOT_N-1:0] wb_slots
);
    localparam int NREG  = 1 << REG_AW;
    localparam int CNT_W = $clog2(SLOT_N);

    unit_t             unit;
    logic [CNT_W-1:0]  lat;
    logic [NREG-1:0]   pend;
    logic              clash;
    logic              haz_raw, haz_waw, haz_div, haz_wb;
    logic              go;

    assign unit = unit_t'(unit_sel);

    always_comb begin
        unique case (unit)
            U_INT:   lat = CNT_W'(LAT_INT);
            U_MUL:   lat = CNT_W'(LAT_MUL);
            U_ADD:   lat = CNT_W'(LAT_ADD);
            U_DIV:   lat = CNT_W'(LAT_DIV);
            default: lat = CNT_W'(LAT_INT);
        endcase
    end

    assign haz_raw = (src_a_vld && pend[src_a]) || (src_b_vld && pend[src_b]);
    assign haz_waw = dst_vld && pend[dst];
    assign haz_div = (unit == U_DIV) && div_busy;
    assign haz_wb  = dst_vld && clash;

    assign stall = issue_req && (haz_raw || haz_waw || haz_div || haz_wb);
    assign go    = issue_req && !stall;

    fpi_pend_table #(.REG_AW(REG_AW), .CNT_W(CNT_W), .LAT_MAX(LAT_MAX)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (go && dst_vld),
        .wr_idx (dst),
        .wr_lat (lat),
        .pend   (pend)
    );

    fpi_wb_ring #(.SLOT_N(SLOT_N), .CNT_W(CNT_W)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .rsv   (go && dst_vld),
        .lat   (lat),
        .clash (clash),
        .slots (wb_slots)
    );

    fpi_div_seq #(.LAT_DIV(LAT_DIV), .CNT_W(CNT_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (go && unit == U_DIV),
        .busy   (div_busy)
    );

    // R8: no request, no stall
    assert_idle_no_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_req |-> !stall);

    // R8: an idle or stalled cycle adds no reservation (slots only shift)
    assert_hold_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> wb_slots == ($past(wb_slots) >> 1));

    // R5: a divide issue keeps the divider busy in the next cycle
    assert_div_occupied_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && unit == U_DIV) |=> div_busy);

    // R3: a pending valid source always blocks issue
    assert_raw_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_req && src_a_vld && pend[src_a]) |-> stall);

endmodule

// File: tb/fpi_issue_guard_test.sv
module fpi_issue_guard_test;
    localparam int AW = 5;
    localparam int SN = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_req = 1'b0;
    logic [1:0]    unit_sel = 2'd0;
    logic [AW-1:0] src_a = '0, src_b = '0, dst = '0;
    logic          src_a_vld = 1'b0, src_b_vld = 1'b0, dst_vld = 1'b0;
    logic          stall, div_busy;
    logic [SN-1:0] wb_slots;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int ready [32];
    int div_free = 0;
    bit wbm [int];
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    fpi_issue_guard uut (
        .clk(clk), .rst_n(rst_n), .issue_req(issue_req), .unit_sel(unit_sel),
        .src_a(src_a), .src_a_vld(src_a_vld), .src_b(src_b), .src_b_vld(src_b_vld),
        .dst(dst), .dst_vld(dst_vld), .stall(stall), .div_busy(div_busy),
        .wb_slots(wb_slots)
    );

    function automatic int lat_of(input int u);
        case (u)
            0: return 1;
            1: return 7;
            2: return 4;
            default: return 24;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // one cycle: drive, compare against model, update model, advance
    task automatic step(input bit req, input int u, input int sa, input bit sav,
                        input int sb, input bit sbv, input int d, input bit dv,
                        output bit issued, output bit stalled);
        bit raw, waw, dvb, wbc, es;
        @(negedge clk);
        issue_req = req; unit_sel = 2'(u);
        src_a = AW'(sa); src_a_vld = sav; src_b = AW'(sb); src_b_vld = sbv;
        dst = AW'(d); dst_vld = dv;
        #1;
        raw = (sav && ready[sa] > cyc) || (sbv && ready[sb] > cyc); // R3, R9
        waw = dv && ready[d] > cyc;                                 // R4
        dvb = (u == 3) && div_free > cyc;                           // R5
        wbc = dv && wbm.exists(cyc + lat_of(u));                    // R7
        es  = req && (raw || waw || dvb || wbc);
        if (!req)      check("R8 stall without request", int'(stall), 0);
        else if (raw)  check("R3 source hazard", int'(stall), int'(es));
        else if (waw)  check("R4 destination hazard", int'(stall), int'(es));
        else if (dvb)  check("R5 divider occupied", int'(stall), int'(es));
        else if (wbc)  check("R7 slot conflict", int'(stall), int'(es));
        else           check("R9 clear request", int'(stall), int'(es));
        check("R5 div_busy", int'(div_busy), int'(div_free > cyc));
        for (int k = 0; k < SN; k++)
            check("R6 wb_slots bit", int'(wb_slots[k]), int'(wbm.exists(cyc + k)));
        issued = req && !es;
        stalled = stall;
        if (issued) begin  // R2
            if (dv) begin
                ready[d] = cyc + lat_of(u) + 1;
                wbm[cyc + lat_of(u)] = 1'b1;
            end
            if (u == 3) div_free = cyc + 25;
        end
        @(posedge clk);
        cyc++;
    endtask

    task automatic idle(input int n);
        bit a, b;
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, a, b);
    endtask

    // present one instruction until it issues; return stalled cycle count
    task automatic until_issued(input int u, input int sa, input bit sav,
                                input int d, input bit dv, output int nst);
        bit iss, st;
        nst = 0;
        iss = 0;
        while (!iss) begin
            step(1, u, sa, sav, 0, 0, d, dv, iss, st);
            if (st) nst++;
        end
    endtask

    initial begin : wdog
        #(5ns * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        int nst;
        bit iss, st;
        bit need;
        int u, sa, sb, d;
        bit sav, sbv, dv, rq;
        for (int r = 0; r < 32; r++) ready[r] = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 stall in reset", int'(stall), 0);
        check("R1 div_busy in reset", int'(div_busy), 0);
        check("R1 wb_slots in reset", int'(wb_slots), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        cyc = 0;
        idle(2);

        // R2 R3: dependence stall length equals producer latency
        for (int p = 0; p < 4; p++)
            for (int q = 0; q < 4; q++) begin
                idle(30);
                until_issued(p, 0, 0, 5, 1, nst);
                until_issued(q, 5, 1, 6, 1, nst);
                check("R2 dependence stall length", nst, lat_of(p));
            end

        // R5: back-to-back divides on unrelated registers
        idle(30);
        until_issued(3, 0, 0, 7, 1, nst);
        until_issued(3, 0, 0, 8, 1, nst);
        check("R5 second divide wait", nst, 24);

        // R7: multiply then add three cycles later collide on write-back
        idle(30);
        until_issued(1, 0, 0, 1, 1, nst);
        idle(2);
        until_issued(2, 0, 0, 2, 1, nst);
        check("R7 slot conflict stall", nst, 1);
        idle(30);
        until_issued(1, 0, 0, 1, 1, nst);
        idle(2);
        until_issued(2, 0, 0, 2, 0, nst);
        check("R7 no destination no slot", nst, 0);

        // R4: write after write on a pending register
        idle(30);
        until_issued(2, 0, 0, 3, 1, nst);
        until_issued(0, 0, 0, 3, 1, nst);
        check("R4 destination wait", nst, 4);

        // R9: invalid sources naming a pending register do not stall
        idle(30);
        until_issued(1, 0, 0, 4, 1, nst);
        step(1, 0, 4, 0, 4, 0, 9, 1, iss, st);
        check("R9 invalid sources ignored", int'(st), 0);

        // R8 and mixed hazards: pseudo-random stream over four registers
        idle(30);
        need = 1;
        {rq, u, sa, sav, sb, sbv, d, dv} = '0;
        for (int i = 0; i < 4000; i++) begin
            if (need) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                u = int'(lf[1:0]); sa = int'(lf[3:2]); sav = lf[4];
                sb = int'(lf[6:5]); sbv = lf[7]; d = int'(lf[9:8]);
                dv = lf[10] | lf[11]; rq = (lf[14:12] != 3'd0);
            end
            step(rq, u, sa, sav, sb, sbv, d, dv, iss, st);
            need = iss || !rq;
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule